// File: doc/BRIEF.md
# AC-link Codec Register Access Unit

This unit gives a host processor access to the control registers of an audio codec over the command slots of an AC-link frame. The host loads a 16-bit value and a register index into two memory-mapped registers. The unit then presents them as the outbound command-address and command-data slot words during the next frame. For a read, it waits for the codec's reply and captures the data that comes back. Bit-level serialization and the PCM streams are handled elsewhere. This block only sees one frame strobe per frame, the inbound slot tags and data that belong to that strobe, and the outbound slot words it must hold steady for the frame.

The host side is a small register file. It holds the command slots, a global control register, and a status group made of raw status, mask and masked status. Events are acknowledged through an end-of-interrupt register, and a level interrupt output is derived from the masked status. The unit also times the codec's cold-reset pulse and the warm-reset SYNC pulse from cycle-count parameters. After either pulse ends, it watches the inbound codec-ready tag so that it can report, once, that the codec has come back up.

Top module: `aclink_cmd_unit`

## Requirements
- R1: After reset, every host register reads 0, `irq` is 0, `codecResetN` is 1, `syncOut` is 0 and both outbound slot-valid flags are 0.
- R2: A write command is formed by writing the data value to offset 0x84 and then the index to offset 0x80. At the next frame strobe with the interface enabled, the unit holds `txSlot1Valid` and `txSlot2Valid` at 1 for that one frame. During that frame, `txSlot1` is the index byte with bit 7 cleared, shifted up by 12 bits, and `txSlot2` is the data value shifted up by 4 bits.
- R3: A write to 0x80 that is not preceded by a write to 0x84 is a read command. Its frame has only `txSlot1Valid` set, and bit 7 of the index byte (`txSlot1` bit 19) is forced to 1.
- R4: The frame strobe that ends a write command's frame clears both valid flags, sets raw status bit 6 (command sent) and clears the busy flag.
- R5: After a read frame, the first frame strobe that carries `rxSlot2Valid` loads `rxSlot2Data[19:4]` into the 0x84 register, sets raw status bit 1 (reply valid) and clears the busy flag.
- R6: Offset 0x94 is the mask register and 0x90 reads raw status (0x8C) ANDed with the mask. `irq` is 1 exactly when that AND is non-zero.
- R7: A read or a write of offset 0x80 or 0x84 clears raw status bits 1 and 6.
- R8: A pulse on `rxWake` sets raw status bit 0. Writing 0x98 with bit 0 set clears status bit 0, and writing it with bit 1 set clears status bit 5.
- R9: Bit 0 of 0x9C enables the interface. While it is 0, a pending command is held and not sent, and 0x9C bit 1 reads 1 while a command is pending or in progress.
- R10: Writes to 0x80 or 0x84 while busy are ignored: the stored index, the stored data and the outbound slot words stay as they were.
- R11: Writing 1 to bit 0 of 0xA0 drives `codecResetN` low for exactly RST_CYCLES clocks. The bit reads 1 during the pulse and 0 once the pulse is over.
- R12: Writing 1 to bit 0 of 0xA4 drives `syncOut` high for exactly SYNC_CYCLES clocks, and that bit reads 1 during the pulse.
- R13: Raw status bit 5 (codec ready) is set by the first frame strobe with `rxCodecReady` after a reset or SYNC pulse has ended. The tag has no effect before any such pulse, and it has no effect a second time after the same pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 8 | Host register byte offset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (has side effects on the slot registers) |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, valid in the cycle hostAddr is presented |
| irq | output | 1 | Level interrupt, high while masked status is non-zero |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| txSlot1 | output | 20 | Outbound command-address slot word |
| txSlot2 | output | 20 | Outbound command-data slot word |
| txSlot1Valid | output | 1 | Command-address slot carries a command in this frame |
| txSlot2Valid | output | 1 | Command-data slot carries data in this frame |
| rxSlot2Valid | input | 1 | Inbound status-data slot valid tag, qualified by frameStrobe |
| rxSlot2Data | input | 20 | Inbound status-data slot word |
| rxCodecReady | input | 1 | Inbound codec-ready tag, qualified by frameStrobe |
| rxWake | input | 1 | Codec wake-up event pulse |
| codecResetN | output | 1 | Active-low cold reset to the codec |
| syncOut | output | 1 | Warm-reset SYNC pulse |

## Verification
The command path is tried with a plain write command, a plain read command, a read command queued while the interface is disabled, and stray slot writes made while that command is pending. The write case separates two-slot frames from one-slot frames and shows that bit 7 is cleared. The read case shows that bit 7 is forced and that reply data is captured. The disabled case shows that the enable gates the launch, and the stray writes show that the stored command is protected while busy. The status group is tried with different masks against the same raw event, so that masked status and `irq` are seen to follow the mask and not the event alone. The codec-ready tag is presented before any reset, after a cold reset, again after its acknowledgement, and after a warm reset, which checks both the arming and the once-only behaviour.

// File: rtl/aclink_cmd_pkg.sv
package aclink_cmd_pkg;

  // Host register byte offsets (software decodes these)
  localparam logic [7:0] OFF_SLOT1  = 8'h80;
  localparam logic [7:0] OFF_SLOT2  = 8'h84;
  localparam logic [7:0] OFF_RAW    = 8'h8C;
  localparam logic [7:0] OFF_MASKED = 8'h90;
  localparam logic [7:0] OFF_MASK   = 8'h94;
  localparam logic [7:0] OFF_ACK    = 8'h98;
  localparam logic [7:0] OFF_CTRL   = 8'h9C;
  localparam logic [7:0] OFF_COLD   = 8'hA0;
  localparam logic [7:0] OFF_WARM   = 8'hA4;

  // Status bit positions shared by raw, mask and masked views
  localparam int STAT_W     = 7;
  localparam int BIT_WAKE   = 0;
  localparam int BIT_REPLY  = 1;
  localparam int BIT_READY  = 5;
  localparam int BIT_SENT   = 6;
  localparam logic [STAT_W-1:0] STAT_IMPL = 7'b110_0011;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_PEND,
    CMD_SEND,
    CMD_WAIT
  } cmdState_t;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic issue;
    logic issueRead;
    logic wrDone;
    logic rdCapture;
    logic setReady;
    logic busy;
    logic coldActive;
    logic warmActive;
  } ctlBus_t;

endpackage

// File: rtl/aclink_pulse_timer.sv
module aclink_pulse_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        remain <= LOAD;
      end
    end else if (remain == '0) begin
      active <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  assign done = active && (remain == '0);

  // A request while idle always opens a pulse on the next cycle
  assert_pulse_starts_R11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !active) |=> active);

endmodule

// File: rtl/aclink_cmd_ctrl.sv
module aclink_cmd_ctrl
  import aclink_cmd_pkg::*;
#(
  parameter int RST_CYCLES  = 100,
  parameter int SYNC_CYCLES = 300
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    cmdStart,
  input  logic    cmdIsRead,
  input  logic    coldReq,
  input  logic    warmReq,
  input  logic    frameStrobe,
  input  logic    rxSlot2Valid,
  input  logic    rxCodecReady,
  output ctlBus_t ctl
);
  cmdState_t state;
  logic      isRead;
  logic      readyArmed;
  logic      coldActive, coldDone;
  logic      warmActive, warmDone;

  aclink_pulse_timer #(.CYCLES(RST_CYCLES)) u_coldTimer (
    .clk(clk), .rstN(rstN), .start(coldReq),
    .active(coldActive), .done(coldDone)
  );

  aclink_pulse_timer #(.CYCLES(SYNC_CYCLES)) u_warmTimer (
    .clk(clk), .rstN(rstN), .start(warmReq),
    .active(warmActive), .done(warmDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= CMD_IDLE;
      isRead <= 1'b0;
    end else begin
      case (state)
        CMD_IDLE: if (cmdStart) begin
          state  <= CMD_PEND;
          isRead <= cmdIsRead;
        end
        CMD_PEND: if (frameStrobe && enable) state <= CMD_SEND;
        CMD_SEND: if (frameStrobe) state <= isRead ? CMD_WAIT : CMD_IDLE;
        CMD_WAIT: if (frameStrobe && rxSlot2Valid) state <= CMD_IDLE;
        default:  state <= CMD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     readyArmed <= 1'b0;
    else if (coldDone || warmDone) readyArmed <= 1'b1;
    else if (ctl.setReady)         readyArmed <= 1'b0;
  end

  always_comb begin
    ctl            = '0;
    ctl.issue      = (state == CMD_PEND) && frameStrobe && enable;
    ctl.issueRead  = isRead;
    ctl.wrDone     = (state == CMD_SEND) && frameStrobe && !isRead;
    ctl.rdCapture  = (state == CMD_WAIT) && frameStrobe && rxSlot2Valid;
    ctl.setReady   = readyArmed && frameStrobe && rxCodecReady;
    ctl.busy       = (state != CMD_IDLE);
    ctl.coldActive = coldActive;
    ctl.warmActive = warmActive;
  end

  // Codec-ready is reported once per reset or SYNC pulse
  assert_ready_once_R13: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setReady && !coldDone && !warmDone) |=> !readyArmed);

endmodule

// File: rtl/aclink_cmd_dp.sv
module aclink_cmd_dp
  import aclink_cmd_pkg::*;
#(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              irq,
  input  logic              frameStrobe,
  input  logic [SLOT_W-1:0] rxSlot2Data,
  input  logic              rxWake,
  input  ctlBus_t           ctl,
  output logic              cmdStart,
  output logic              cmdIsRead,
  output logic              coldReq,
  output logic              warmReq,
  output logic              enable,
  output logic [SLOT_W-1:0] txSlot1,
  output logic [SLOT_W-1:0] txSlot2,
  output logic              txSlot1Valid,
  output logic              txSlot2Valid
);
  localparam int IDX_W = 8;
  localparam int CMD_W = 16;
  localparam int PAD1  = SLOT_W - IDX_W;
  localparam int PAD2  = SLOT_W - CMD_W;

  logic [IDX_W-1:0]  slot1Reg;
  logic [CMD_W-1:0]  slot2Reg;
  logic [STAT_W-1:0] rawStat, maskReg, statNext, maskedStat;
  logic              enableReg, dataArmed;
  logic              slot1Wr, slot2Wr, slotTouch, ackWr, ctrlWr, maskWr;
  logic              unusedBits;

  assign slot1Wr   = hostWrEn && (hostAddr == OFF_SLOT1);
  assign slot2Wr   = hostWrEn && (hostAddr == OFF_SLOT2);
  assign slotTouch = (hostWrEn || hostRdEn) &&
                     ((hostAddr == OFF_SLOT1) || (hostAddr == OFF_SLOT2));
  assign ackWr     = hostWrEn && (hostAddr == OFF_ACK);
  assign ctrlWr    = hostWrEn && (hostAddr == OFF_CTRL);
  assign maskWr    = hostWrEn && (hostAddr == OFF_MASK);
  assign coldReq   = hostWrEn && (hostAddr == OFF_COLD) && hostWrData[0];
  assign warmReq   = hostWrEn && (hostAddr == OFF_WARM) && hostWrData[0];
  assign cmdStart  = slot1Wr && !ctl.busy;
  assign cmdIsRead = !dataArmed;
  assign enable    = enableReg;
  assign unusedBits = ^{hostWrData[31:CMD_W], rxSlot2Data[PAD2-1:0]};

  always_comb begin
    statNext = rawStat;
    if (slotTouch) begin
      statNext[BIT_REPLY] = 1'b0;
      statNext[BIT_SENT]  = 1'b0;
    end
    if (ackWr && hostWrData[0]) statNext[BIT_WAKE]  = 1'b0;
    if (ackWr && hostWrData[1]) statNext[BIT_READY] = 1'b0;
    if (rxWake)        statNext[BIT_WAKE]  = 1'b1;
    if (ctl.rdCapture) statNext[BIT_REPLY] = 1'b1;
    if (ctl.setReady)  statNext[BIT_READY] = 1'b1;
    if (ctl.wrDone)    statNext[BIT_SENT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot1Reg     <= '0;
      slot2Reg     <= '0;
      dataArmed    <= 1'b0;
      enableReg    <= 1'b0;
      maskReg      <= '0;
      rawStat      <= '0;
      txSlot1Valid <= 1'b0;
      txSlot2Valid <= 1'b0;
    end else begin
      if (cmdStart) slot1Reg <= {!dataArmed, hostWrData[IDX_W-2:0]};
      if (slot2Wr && !ctl.busy)  slot2Reg <= hostWrData[CMD_W-1:0];
      else if (ctl.rdCapture)    slot2Reg <= rxSlot2Data[SLOT_W-1 -: CMD_W];
      if (cmdStart)                  dataArmed <= 1'b0;
      else if (slot2Wr && !ctl.busy) dataArmed <= 1'b1;
      if (ctrlWr) enableReg <= hostWrData[0];
      if (maskWr) maskReg   <= hostWrData[STAT_W-1:0] & STAT_IMPL;
      rawStat <= statNext;
      if (ctl.issue) begin
        txSlot1Valid <= 1'b1;
        txSlot2Valid <= !ctl.issueRead;
      end else if (frameStrobe) begin
        txSlot1Valid <= 1'b0;
        txSlot2Valid <= 1'b0;
      end
    end
  end

  assign txSlot1    = {slot1Reg, {PAD1{1'b0}}};
  assign txSlot2    = {slot2Reg, {PAD2{1'b0}}};
  assign maskedStat = rawStat & maskReg;
  assign irq        = |maskedStat;

  always_comb begin
    case (hostAddr)
      OFF_SLOT1:  hostRdData = 32'(slot1Reg);
      OFF_SLOT2:  hostRdData = 32'(slot2Reg);
      OFF_RAW:    hostRdData = 32'(rawStat);
      OFF_MASKED: hostRdData = 32'(maskedStat);
      OFF_MASK:   hostRdData = 32'(maskReg);
      OFF_CTRL:   hostRdData = {30'd0, ctl.busy, enableReg};
      OFF_COLD:   hostRdData = {31'd0, ctl.coldActive};
      OFF_WARM:   hostRdData = {31'd0, ctl.warmActive};
      default:    hostRdData = '0;
    endcase
  end

  assert_issue_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> enableReg);

  assert_index_held_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && $past(ctl.busy)) |-> $stable(slot1Reg));

  assert_sent_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrDone |=> rawStat[BIT_SENT]);

  assert_ready_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && hostWrData[1] && !ctl.setReady) |=> !rawStat[BIT_READY]);

  assert_read_frame_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txSlot1Valid && !txSlot2Valid) |-> txSlot1[SLOT_W-1]);

  assert_data_needs_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    txSlot2Valid |-> txSlot1Valid);

  assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskReg != '0));

endmodule

// File: rtl/aclink_cmd_unit.sv
module aclink_cmd_unit
  import aclink_cmd_pkg::*;
#(
  parameter int RST_CYCLES  = 100,
  parameter int SYNC_CYCLES = 300,
  parameter int SLOT_W      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              irq,
  input  logic              frameStrobe,
  output logic [SLOT_W-1:0] txSlot1,
  output logic [SLOT_W-1:0] txSlot2,
  output logic              txSlot1Valid,
  output logic              txSlot2Valid,
  input  logic              rxSlot2Valid,
  input  logic [SLOT_W-1:0] rxSlot2Data,
  input  logic              rxCodecReady,
  input  logic              rxWake,
  output logic              codecResetN,
  output logic              syncOut
);
  ctlBus_t ctl;
  logic    cmdStart, cmdIsRead, coldReq, warmReq, enable;

  aclink_cmd_ctrl #(.RST_CYCLES(RST_CYCLES), .SYNC_CYCLES(SYNC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cmdStart(cmdStart), .cmdIsRead(cmdIsRead),
    .coldReq(coldReq), .warmReq(warmReq),
    .frameStrobe(frameStrobe), .rxSlot2Valid(rxSlot2Valid),
    .rxCodecReady(rxCodecReady), .ctl(ctl)
  );

  aclink_cmd_dp #(.SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq),
    .frameStrobe(frameStrobe), .rxSlot2Data(rxSlot2Data), .rxWake(rxWake),
    .ctl(ctl), .cmdStart(cmdStart), .cmdIsRead(cmdIsRead),
    .coldReq(coldReq), .warmReq(warmReq), .enable(enable),
    .txSlot1(txSlot1), .txSlot2(txSlot2),
    .txSlot1Valid(txSlot1Valid), .txSlot2Valid(txSlot2Valid)
  );

  assign codecResetN = !ctl.coldActive;
  assign syncOut     = ctl.warmActive;

endmodule

// File: tb/aclink_cmd_unit_tb.sv
module aclink_cmd_unit_tb;
  localparam int RST_CYC  = 100;
  localparam int SYNC_CYC = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic        irq, frameStrobe = 1'b0;
  logic [19:0] txSlot1, txSlot2, rxSlot2Data = '0;
  logic        txSlot1Valid, txSlot2Valid;
  logic        rxSlot2Valid = 1'b0, rxCodecReady = 1'b0, rxWake = 1'b0;
  logic        codecResetN, syncOut;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  aclink_cmd_unit #(.RST_CYCLES(RST_CYC), .SYNC_CYCLES(SYNC_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irq(irq), .frameStrobe(frameStrobe), .txSlot1(txSlot1), .txSlot2(txSlot2),
    .txSlot1Valid(txSlot1Valid), .txSlot2Valid(txSlot2Valid),
    .rxSlot2Valid(rxSlot2Valid), .rxSlot2Data(rxSlot2Data),
    .rxCodecReady(rxCodecReady), .rxWake(rxWake),
    .codecResetN(codecResetN), .syncOut(syncOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData;
    @(posedge clk); @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic frame(input logic rv, input logic [15:0] rd, input logic rdy);
    frameStrobe = 1'b1; rxSlot2Valid = rv; rxSlot2Data = {rd, 4'h0}; rxCodecReady = rdy;
    @(posedge clk); @(negedge clk);
    frameStrobe = 1'b0; rxSlot2Valid = 1'b0; rxCodecReady = 1'b0;
  endtask

  task automatic testResetState();
    logic [31:0] v;
    hostRead(8'h8C, v); chk("R1 raw status", v, 0);
    hostRead(8'h9C, v); chk("R1 control", v, 0);
    hostRead(8'h94, v); chk("R1 mask", v, 0);
    chk("R1 pins", {irq, codecResetN, syncOut, txSlot1Valid, txSlot2Valid}, 5'b01000);
  endtask

  task automatic testDisabledAndBusy();
    logic [31:0] v;
    hostWrite(8'h80, 32'h12);              // read command, interface off
    frame(1'b0, 16'h0, 1'b0);
    frame(1'b0, 16'h0, 1'b0);
    chk("R9 no frame while disabled", {txSlot1Valid, txSlot2Valid}, 2'b00);
    hostRead(8'h9C, v); chk("R9 busy visible", v, 32'h2);
    hostWrite(8'h84, 32'h5555);            // ignored while busy
    hostWrite(8'h80, 32'h33);
    hostRead(8'h80, v); chk("R10 index kept", v, 32'h92);
    hostWrite(8'h9C, 32'h1);
    frame(1'b0, 16'h0, 1'b0);
    chk("R3 read frame valids", {txSlot1Valid, txSlot2Valid}, 2'b10);
    chk("R3 read flag in slot1", txSlot1, 32'h92000);
    chk("R10 slot2 word kept", txSlot2, 0);
    frame(1'b0, 16'h0, 1'b0);
    frame(1'b1, 16'h1234, 1'b0);
    hostRead(8'h8C, v); chk("R5 reply flag", v, 32'h02);
    hostRead(8'h9C, v); chk("R5 busy cleared", v, 32'h1);
    hostRead(8'h84, v); chk("R5 reply data", v, 32'h1234);
    hostRead(8'h8C, v); chk("R7 reply flag cleared by slot read", v, 0);
  endtask

  task automatic testWriteCmd();
    logic [31:0] v;
    hostWrite(8'h84, 32'hA5C3);
    hostWrite(8'h80, 32'h8C);
    frame(1'b0, 16'h0, 1'b0);
    chk("R2 write frame valids", {txSlot1Valid, txSlot2Valid}, 2'b11);
    chk("R2 slot1 word", txSlot1, 32'h0C000);
    chk("R2 slot2 word", txSlot2, 32'hA5C30);
    frame(1'b0, 16'h0, 1'b0);
    chk("R4 valids cleared", {txSlot1Valid, txSlot2Valid}, 2'b00);
    hostRead(8'h8C, v); chk("R4 sent flag", v, 32'h40);
    hostRead(8'h9C, v); chk("R4 busy cleared", v, 32'h1);
    hostWrite(8'h94, 32'h40);
    chk("R6 irq with mask", irq, 1);
    hostRead(8'h90, v); chk("R6 masked view", v, 32'h40);
    hostWrite(8'h94, 32'h02);
    chk("R6 irq masked off", irq, 0);
    hostRead(8'h90, v); chk("R6 masked view off", v, 0);
    hostWrite(8'h80, 32'h0);               // starts a read, clears sent flag
    hostRead(8'h8C, v); chk("R7 sent flag cleared by slot write", v, 0);
    frame(1'b0, 16'h0, 1'b0);
    frame(1'b0, 16'h0, 1'b0);
    frame(1'b1, 16'h00FF, 1'b0);
    hostRead(8'h84, v);
  endtask

  task automatic testWake();
    logic [31:0] v;
    rxWake = 1'b1; @(posedge clk); @(negedge clk); rxWake = 1'b0;
    hostRead(8'h8C, v); chk("R8 wake flag set", v, 32'h01);
    hostWrite(8'h98, 32'h1);
    hostRead(8'h8C, v); chk("R8 wake flag cleared", v, 0);
  endtask

  task automatic testPulsesAndReady();
    logic [31:0] v;
    int n;
    frame(1'b0, 16'h0, 1'b1);
    hostRead(8'h8C, v); chk("R13 tag ignored before reset", v, 0);
    hostWrite(8'hA0, 32'h1);
    hostRead(8'hA0, v); chk("R11 reset bit busy", v, 1);
    n = 0;
    while (!codecResetN && n < 1000) begin n++; @(negedge clk); end
    chk("R11 reset width", n, RST_CYC - 1);
    hostRead(8'hA0, v); chk("R11 reset bit self-clears", v, 0);
    frame(1'b0, 16'h0, 1'b1);
    hostRead(8'h8C, v); chk("R13 ready after reset", v, 32'h20);
    hostWrite(8'h98, 32'h2);
    hostRead(8'h8C, v); chk("R8 ready cleared", v, 0);
    frame(1'b0, 16'h0, 1'b1);
    hostRead(8'h8C, v); chk("R13 ready only once", v, 0);
    hostWrite(8'hA4, 32'h1);
    n = 0;
    while (syncOut && n < 1000) begin n++; @(negedge clk); end
    chk("R12 sync width", n, SYNC_CYC);
    hostRead(8'hA4, v); chk("R12 sync bit self-clears", v, 0);
    hostWrite(8'h94, 32'h20);
    frame(1'b0, 16'h0, 1'b1);
    chk("R13 ready after warm reset raises irq", irq, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testDisabledAndBusy();
    testWriteCmd();
    testWake();
    testPulsesAndReady();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule